// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block is a small translation buffer that sits inside a memory management unit. Each slot holds a virtual page number, a physical frame number, protection bits, a modified flag and a valid flag. A lookup compares the presented virtual page number against every slot in the same cycle. On a hit it returns the frame and the protection bits, and on a write it marks the page as modified. On a miss it asks an external page-table port for the entry and installs the answer in a slot. It uses a free slot if there is one, and otherwise a slot picked by a free-running pseudo-random sequence.

When the chosen slot already holds a modified page, the block first reports that page's virtual page number on a write-back port. This lets the page-table copy of the modified flag be updated. Only after that write-back is accepted is the slot overwritten. A read-only page that is written raises a protection fault. A page-table answer that marks the page absent raises a page fault and installs nothing. A flush input invalidates all slots. A flush that arrives while a refill or a write-back is in progress is held back until the block is idle again.

Top module: `xlat_buf`

## Requirements
- R1: After reset every slot is invalid and `lk_done`, `lk_hit`, `pt_req` and `wb_valid` are low. `lk_ready` is high, and the first lookup of any page misses.
- R2: A lookup of a resident page gives `lk_done=1`, `lk_hit=1`, the stored frame and protection bits one clock edge after it is accepted. It raises no `pt_req`.
- R3: A lookup that misses raises `pt_req` with `pt_req_vpn` equal to the looked-up page one edge after acceptance. Both stay unchanged until the edge where `pt_rsp_valid` is sampled high.
- R4: A response with `pt_rsp_present=1` installs the entry and completes the lookup with `lk_hit=0` and the returned frame and protection. A later lookup of that page hits.
- R5: While any slot is invalid, a refill uses an invalid slot. It never evicts or writes back a resident page.
- R6: When all slots are valid, the victim comes from a free-running pseudo-random sequence. Exactly one resident page is replaced, and every other resident page still hits.
- R7: A victim whose modified flag is set is reported on `wb_valid`/`wb_vpn`. Both are held stable until `wb_ready` is sampled high, and the new entry is installed and the lookup completed on that same edge.
- R8: A victim whose modified flag is clear is replaced without any write-back.
- R9: A write lookup that hits a writable page sets that page's modified flag, so a later eviction of it is written back. Protection bit 0 set means writable. An entry installed by a write refill of a writable page is also marked modified.
- R10: A write to a page whose protection bit 0 is clear completes with `lk_prot_fault=1` and leaves the modified flag clear. This holds both on a hit and on a refill.
- R11: A response with `pt_rsp_present=0` completes the lookup with `lk_page_fault=1` and `lk_hit=0`, and installs nothing. A repeat lookup misses again.
- R12: A `flush` pulse while idle invalidates all slots. A `flush` while a refill or write-back is in progress is applied once the block is idle again, and `lk_ready` stays low until the flush is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all slots (deferred while busy) |
| lk_valid | input | 1 | Lookup request, taken when `lk_ready` is high |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_write | input | 1 | Lookup is for a store |
| lk_ready | output | 1 | Block idle and able to take a lookup |
| lk_done | output | 1 | One-cycle completion of a lookup |
| lk_hit | output | 1 | Completed lookup was found resident |
| lk_pfn | output | PFN_W | Translated physical frame number |
| lk_prot | output | PROT_W | Protection bits of the page (bit 0 = writable) |
| lk_prot_fault | output | 1 | Store to a read-only page |
| lk_page_fault | output | 1 | Page-table reports page absent |
| pt_req | output | 1 | Page-table request pending |
| pt_req_vpn | output | VPN_W | Page requested from the page table |
| pt_rsp_valid | input | 1 | Page-table response strobe |
| pt_rsp_present | input | 1 | Page is present in memory |
| pt_rsp_pfn | input | PFN_W | Frame number from the page table |
| pt_rsp_prot | input | PROT_W | Protection bits from the page table |
| pt_rsp_mod | input | 1 | Modified flag from the page table |
| wb_valid | output | 1 | Modified flag of an evicted page to be written back |
| wb_vpn | output | VPN_W | Page whose modified flag is written back |
| wb_ready | input | 1 | Write-back accepted |

## Verification
A hit completes on the first edge after acceptance, so the bench samples `lk_done` at the falling edge that follows it. A miss shows `pt_req` at that same falling edge. The bench holds off its response for two more cycles to observe the hold, and expects completion one edge after the response, or one edge after `wb_ready` when a write-back was needed. Write-backs are also acknowledged two cycles late, so that stability of `wb_vpn` is observed. Because the victim is pseudo-random, the bench learns it from `wb_vpn` when every slot is modified, keeps its own model of the resident set, and then probes every model page for a hit.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_WB   = 2'd2
  } xlat_state_e;

  // position of the writable flag inside the protection field
  localparam int PROT_WR_BIT = 0;
endpackage

// File: rtl/xlat_lfsr.sv
module xlat_lfsr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] value
);
  logic [W-1:0] s_q;

  always_ff @(posedge clk) begin
    if (rst) s_q <= W'(1);
    else if (s_q[0]) s_q <= (s_q >> 1) ^ TAPS;
    else s_q <= s_q >> 1;
  end

  assign value = s_q;

  // R6
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst) s_q != '0);
endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int IDX_W = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [VPN_W-1:0]          key,
  input  logic [N-1:0]              ent_vld,
  input  logic [N-1:0][VPN_W-1:0]   ent_vpn,
  output logic                      hit,
  output logic [IDX_W-1:0]          hit_idx,
  output logic                      free_any,
  output logic [IDX_W-1:0]          free_idx
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = ent_vld[g] && (ent_vpn[g] == key);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (eq[i]) hit_idx = IDX_W'(i);
    end
  end

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!ent_vld[i]) free_idx = IDX_W'(i);
    end
  end

  assign hit      = |eq;
  assign free_any = ~&ent_vld;

  // R2: a page is never resident in two slots
  match_unique_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(eq));
endmodule

// File: rtl/xlat_store.sv
module xlat_store #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 16,
  parameter int PROT_W = 2,
  parameter int IDX_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush_all,
  input  logic                     ins_we,
  input  logic [IDX_W-1:0]         ins_idx,
  input  logic [VPN_W-1:0]         ins_vpn,
  input  logic [PFN_W-1:0]         ins_pfn,
  input  logic [PROT_W-1:0]        ins_prot,
  input  logic                     ins_mod,
  input  logic                     mod_set,
  input  logic [IDX_W-1:0]         mod_idx,
  output logic [N-1:0]             vld_q,
  output logic [N-1:0]             mod_q,
  output logic [N-1:0][VPN_W-1:0]  vpn_q,
  output logic [N-1:0][PFN_W-1:0]  pfn_q,
  output logic [N-1:0][PROT_W-1:0] prot_q
);
  // flags carry a reset; the payload fields do not
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      mod_q <= '0;
    end else if (flush_all) begin
      vld_q <= '0;
      mod_q <= '0;
    end else begin
      if (ins_we) begin
        vld_q[ins_idx] <= 1'b1;
        mod_q[ins_idx] <= ins_mod;
      end
      if (mod_set) mod_q[mod_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_we) begin
      vpn_q[ins_idx]  <= ins_vpn;
      pfn_q[ins_idx]  <= ins_pfn;
      prot_q[ins_idx] <= ins_prot;
    end
  end

  // R12
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst) flush_all |=> (vld_q == '0));
  // R5
  ins_mod_excl_chk: assert property (@(posedge clk) disable iff (rst) !(ins_we && mod_set));
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf #(
  parameter int          NUM_ENT = 8,
  parameter int          VPN_W   = 20,
  parameter int          PFN_W   = 16,
  parameter int          PROT_W  = 2,
  parameter int          LFSR_W  = 8,
  parameter logic [7:0]  LFSR_TAPS = 8'hB8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic              lk_write,
  output logic              lk_ready,
  output logic              lk_done,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [PROT_W-1:0] lk_prot,
  output logic              lk_prot_fault,
  output logic              lk_page_fault,
  output logic              pt_req,
  output logic [VPN_W-1:0]  pt_req_vpn,
  input  logic              pt_rsp_valid,
  input  logic              pt_rsp_present,
  input  logic [PFN_W-1:0]  pt_rsp_pfn,
  input  logic [PROT_W-1:0] pt_rsp_prot,
  input  logic              pt_rsp_mod,
  output logic              wb_valid,
  output logic [VPN_W-1:0]  wb_vpn,
  input  logic              wb_ready
);
  import xlat_pkg::*;

  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

  xlat_state_e state_q;

  logic [NUM_ENT-1:0]             vld_a, mod_a;
  logic [NUM_ENT-1:0][VPN_W-1:0]  vpn_a;
  logic [NUM_ENT-1:0][PFN_W-1:0]  pfn_a;
  logic [NUM_ENT-1:0][PROT_W-1:0] prot_a;

  logic             m_hit, free_any;
  logic [IDX_W-1:0] hit_idx, free_idx, victim, vic_q;
  logic [LFSR_W-1:0] lfsr_v;

  logic             req_wr_q, flush_pend_q;
  logic [PFN_W-1:0] rsp_pfn_q;
  logic [PROT_W-1:0] rsp_prot_q;
  logic             rsp_mod_q;

  logic accept, flush_do, need_wb;
  logic ins_from_rsp, ins_from_q, ins_we;
  logic [IDX_W-1:0]  ins_idx;
  logic [PFN_W-1:0]  src_pfn;
  logic [PROT_W-1:0] src_prot;
  logic              src_mod, src_wr_ok, ins_mod;
  logic              mod_set;
  logic [PROT_W-1:0] hit_prot;
  logic              hit_wr_ok;

  xlat_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS[LFSR_W-1:0])) u_rand (
    .clk(clk), .rst(rst), .value(lfsr_v)
  );

  xlat_match #(.N(NUM_ENT), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_match (
    .clk(clk), .rst(rst), .key(lk_vpn), .ent_vld(vld_a), .ent_vpn(vpn_a),
    .hit(m_hit), .hit_idx(hit_idx), .free_any(free_any), .free_idx(free_idx)
  );

  // control decode
  assign flush_do = (state_q == ST_IDLE) && (flush || flush_pend_q);
  assign lk_ready = (state_q == ST_IDLE) && !flush && !flush_pend_q;
  assign accept   = lk_valid && lk_ready;

  assign victim  = free_any ? free_idx
                            : IDX_W'(lfsr_v % LFSR_W'(NUM_ENT));
  assign need_wb = vld_a[victim] && mod_a[victim];

  assign hit_prot  = prot_a[hit_idx];
  assign hit_wr_ok = hit_prot[PROT_WR_BIT];
  assign mod_set   = accept && m_hit && lk_write && hit_wr_ok;

  assign ins_from_rsp = (state_q == ST_WAIT) && pt_rsp_valid && pt_rsp_present && !need_wb;
  assign ins_from_q   = (state_q == ST_WB) && wb_ready;
  assign ins_we       = ins_from_rsp || ins_from_q;
  assign ins_idx      = ins_from_q ? vic_q : victim;
  assign src_pfn      = ins_from_q ? rsp_pfn_q  : pt_rsp_pfn;
  assign src_prot     = ins_from_q ? rsp_prot_q : pt_rsp_prot;
  assign src_mod      = ins_from_q ? rsp_mod_q  : pt_rsp_mod;
  assign src_wr_ok    = src_prot[PROT_WR_BIT];
  assign ins_mod      = src_mod || (req_wr_q && src_wr_ok);

  xlat_store #(
    .N(NUM_ENT), .VPN_W(VPN_W), .PFN_W(PFN_W), .PROT_W(PROT_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst(rst), .flush_all(flush_do),
    .ins_we(ins_we), .ins_idx(ins_idx), .ins_vpn(pt_req_vpn),
    .ins_pfn(src_pfn), .ins_prot(src_prot), .ins_mod(ins_mod),
    .mod_set(mod_set), .mod_idx(hit_idx),
    .vld_q(vld_a), .mod_q(mod_a), .vpn_q(vpn_a), .pfn_q(pfn_a), .prot_q(prot_a)
  );

  // sequencing and registered results
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      pt_req        <= 1'b0;
      pt_req_vpn    <= '0;
      req_wr_q      <= 1'b0;
      wb_valid      <= 1'b0;
      wb_vpn        <= '0;
      vic_q         <= '0;
      rsp_pfn_q     <= '0;
      rsp_prot_q    <= '0;
      rsp_mod_q     <= 1'b0;
      flush_pend_q  <= 1'b0;
      lk_done       <= 1'b0;
      lk_hit        <= 1'b0;
      lk_pfn        <= '0;
      lk_prot       <= '0;
      lk_prot_fault <= 1'b0;
      lk_page_fault <= 1'b0;
    end else begin
      lk_done       <= 1'b0;
      lk_hit        <= 1'b0;
      lk_prot_fault <= 1'b0;
      lk_page_fault <= 1'b0;

      if (flush && state_q != ST_IDLE) flush_pend_q <= 1'b1;
      else if (flush_do)               flush_pend_q <= 1'b0;

      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (m_hit) begin
              lk_done       <= 1'b1;
              lk_hit        <= 1'b1;
              lk_pfn        <= pfn_a[hit_idx];
              lk_prot       <= hit_prot;
              lk_prot_fault <= lk_write && !hit_wr_ok;
            end else begin
              state_q    <= ST_WAIT;
              pt_req     <= 1'b1;
              pt_req_vpn <= lk_vpn;
              req_wr_q   <= lk_write;
            end
          end
        end
        ST_WAIT: begin
          if (pt_rsp_valid) begin
            pt_req     <= 1'b0;
            rsp_pfn_q  <= pt_rsp_pfn;
            rsp_prot_q <= pt_rsp_prot;
            rsp_mod_q  <= pt_rsp_mod;
            vic_q      <= victim;
            if (!pt_rsp_present) begin
              state_q       <= ST_IDLE;
              lk_done       <= 1'b1;
              lk_page_fault <= 1'b1;
            end else if (need_wb) begin
              state_q  <= ST_WB;
              wb_valid <= 1'b1;
              wb_vpn   <= vpn_a[victim];
            end else begin
              state_q       <= ST_IDLE;
              lk_done       <= 1'b1;
              lk_pfn        <= pt_rsp_pfn;
              lk_prot       <= pt_rsp_prot;
              lk_prot_fault <= req_wr_q && !src_wr_ok;
            end
          end
        end
        ST_WB: begin
          if (wb_ready) begin
            wb_valid      <= 1'b0;
            state_q       <= ST_IDLE;
            lk_done       <= 1'b1;
            lk_pfn        <= rsp_pfn_q;
            lk_prot       <= rsp_prot_q;
            lk_prot_fault <= req_wr_q && !src_wr_ok;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pt_req && !pt_rsp_valid) |=> (pt_req && $stable(pt_req_vpn)));
  // R7
  wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_vpn)));
  // R7
  wb_req_excl_chk: assert property (@(posedge clk) disable iff (rst) !(wb_valid && pt_req));
  // R11
  pf_nohit_chk: assert property (@(posedge clk) disable iff (rst)
    lk_page_fault |-> (lk_done && !lk_hit && !lk_prot_fault));
  // R10
  prot_fault_done_chk: assert property (@(posedge clk) disable iff (rst) lk_prot_fault |-> lk_done);
  // R12
  flush_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (flush && wb_valid) |=> (wb_valid || lk_done));
endmodule

// File: tb/xlat_buf_test.sv
`timescale 1ns/1ps
module xlat_buf_test;
  localparam int N = 8, VPN_W = 20, PFN_W = 16, PROT_W = 2;

  logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
  logic lk_valid = 1'b0, lk_write = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic lk_ready, lk_done, lk_hit, lk_prot_fault, lk_page_fault;
  logic [PFN_W-1:0] lk_pfn;
  logic [PROT_W-1:0] lk_prot;
  logic pt_req, wb_valid;
  logic [VPN_W-1:0] pt_req_vpn, wb_vpn;
  logic pt_rsp_valid = 1'b0, pt_rsp_present = 1'b0, pt_rsp_mod = 1'b0, wb_ready = 1'b0;
  logic [PFN_W-1:0] pt_rsp_pfn = '0;
  logic [PROT_W-1:0] pt_rsp_prot = '0;

  int total = 0, bad = 0;
  logic g_present = 1'b1;
  logic [PROT_W-1:0] g_prot = 2'b01;
  logic [VPN_W-1:0] model [N];

  // last lookup results
  logic r_hit, r_pf, r_prf, r_req, r_wb;
  logic [PFN_W-1:0] r_pfn;
  logic [PROT_W-1:0] r_prot;
  logic [VPN_W-1:0] r_wbvpn;

  always #2 clk = ~clk;

  xlat_buf uut (
    .clk(clk), .rst(rst), .flush(flush), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .lk_write(lk_write), .lk_ready(lk_ready), .lk_done(lk_done), .lk_hit(lk_hit),
    .lk_pfn(lk_pfn), .lk_prot(lk_prot), .lk_prot_fault(lk_prot_fault),
    .lk_page_fault(lk_page_fault), .pt_req(pt_req), .pt_req_vpn(pt_req_vpn),
    .pt_rsp_valid(pt_rsp_valid), .pt_rsp_present(pt_rsp_present),
    .pt_rsp_pfn(pt_rsp_pfn), .pt_rsp_prot(pt_rsp_prot), .pt_rsp_mod(pt_rsp_mod),
    .wb_valid(wb_valid), .wb_vpn(wb_vpn), .wb_ready(wb_ready)
  );

  function automatic logic [PFN_W-1:0] frame_of(input logic [VPN_W-1:0] v);
    return PFN_W'(v * 5 + 3);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary_end();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    summary_end();
  end

  // one lookup, acting as page table and write-back sink
  task automatic lookup(input logic [VPN_W-1:0] v, input logic wr, input logic inj_flush);
    int req_n = 0, wb_n = 0, it = 0;
    logic rsp_given = 1'b0, done_seen = 1'b0, fl_done = 1'b0;
    r_req = 1'b0; r_wb = 1'b0; r_wbvpn = '0;
    @(negedge clk);
    while (!lk_ready) @(negedge clk);
    lk_vpn = v; lk_write = wr; lk_valid = 1'b1;
    while (!done_seen && it < 60) begin
      @(negedge clk);
      it++;
      lk_valid = 1'b0; pt_rsp_valid = 1'b0; wb_ready = 1'b0;
      if (flush) begin
        flush = 1'b0;
        chk(!lk_ready, "R12 ready low while flush pending", 32'(lk_ready), 0);
      end
      if (lk_done) begin
        done_seen = 1'b1;
        r_hit = lk_hit; r_pf = lk_page_fault; r_prf = lk_prot_fault;
        r_pfn = lk_pfn; r_prot = lk_prot;
      end else begin
        if (pt_req && !rsp_given) begin
          r_req = 1'b1;
          req_n++;
          if (req_n == 1 || req_n == 3)
            chk(pt_req_vpn == v, "R3 request page held", 32'(pt_req_vpn), 32'(v));
          if (inj_flush && !fl_done) begin flush = 1'b1; fl_done = 1'b1; end
          if (req_n == 3) begin
            pt_rsp_valid = 1'b1; pt_rsp_present = g_present;
            pt_rsp_pfn = frame_of(v); pt_rsp_prot = g_prot; pt_rsp_mod = 1'b0;
            rsp_given = 1'b1;
          end
        end
        if (wb_valid) begin
          wb_n++;
          if (wb_n == 1) begin r_wb = 1'b1; r_wbvpn = wb_vpn; end
          else chk(wb_vpn == r_wbvpn, "R7 write-back page stable", 32'(wb_vpn), 32'(r_wbvpn));
          if (wb_n == 3) wb_ready = 1'b1;
        end
      end
    end
    if (!done_seen) chk(1'b0, "R2 lookup completion", 0, 1);
  endtask

  task automatic do_flush();
    @(negedge clk);
    while (!lk_ready) @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic fill(input logic [VPN_W-1:0] base, input logic [PROT_W-1:0] pr);
    g_prot = pr;
    for (int i = 0; i < N; i++) begin
      lookup(base + VPN_W'(i), 1'b0, 1'b0);
      model[i] = base + VPN_W'(i);
      chk(r_req && !r_hit, "R4 refill miss", 32'(r_hit), 0);
      chk(r_pfn == frame_of(model[i]), "R4 installed frame", 32'(r_pfn), 32'(frame_of(model[i])));
      chk(!r_wb, "R5 free slot used, no write-back", 32'(r_wb), 0);
    end
  endtask

  task automatic probe_all(input string req);
    for (int i = 0; i < N; i++) begin
      lookup(model[i], 1'b0, 1'b0);
      chk(r_hit && !r_req, req, 32'(r_hit), 1);
      chk(r_pfn == frame_of(model[i]), req, 32'(r_pfn), 32'(frame_of(model[i])));
    end
  endtask

  initial begin
    int found;
    logic [VPN_W-1:0] nv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!lk_done && !lk_hit && !pt_req && !wb_valid, "R1 outputs idle after reset",
        {lk_done, lk_hit, pt_req, wb_valid}, 0);
    chk(lk_ready, "R1 ready after reset", 32'(lk_ready), 1);
    lookup(20'h00010, 1'b0, 1'b0);
    chk(r_req && !r_hit, "R1 first lookup misses", 32'(r_hit), 0);

    // R4 / R5 / R2: fill with writable pages, then hit all
    do_flush();
    fill(20'h00100, 2'b01);
    probe_all("R2 resident page hits");
    chk(r_prot == 2'b01, "R2 protection returned", 32'(r_prot), 1);

    // R8: all clean, miss evicts silently
    lookup(20'h00200, 1'b0, 1'b0);
    chk(!r_wb, "R8 clean victim not written back", 32'(r_wb), 0);
    lookup(20'h00200, 1'b0, 1'b0);
    chk(r_hit, "R4 repeated access hits", 32'(r_hit), 1);

    // R9: write hits mark modified, then evictions write back
    do_flush();
    fill(20'h00300, 2'b01);
    for (int i = 0; i < N; i++) begin
      lookup(model[i], 1'b1, 1'b0);
      chk(r_hit && !r_prf, "R9 write hit on writable page", {r_hit, r_prf}, 2);
    end
    // R6 / R7: random evictions, victim learnt from write-back
    for (int k = 0; k < 16; k++) begin
      nv = 20'h00400 + VPN_W'(k);
      lookup(nv, 1'b1, 1'b0);
      chk(r_wb, "R9 modified victim written back", 32'(r_wb), 1);
      found = -1;
      for (int i = 0; i < N; i++) if (model[i] == r_wbvpn) found = i;
      chk(found >= 0, "R6 victim was resident", 32'(r_wbvpn), 0);
      if (found >= 0) model[found] = nv;
      chk(!r_hit && r_pfn == frame_of(nv), "R7 install after write-back", 32'(r_pfn), 32'(frame_of(nv)));
    end
    probe_all("R6 other pages still hit");

    // R10: read-only pages
    do_flush();
    fill(20'h00500, 2'b00);
    for (int i = 0; i < N; i++) begin
      lookup(model[i], 1'b1, 1'b0);
      chk(r_hit && r_prf, "R10 write to read-only faults", {r_hit, r_prf}, 3);
    end
    lookup(20'h00600, 1'b1, 1'b0);
    chk(!r_wb, "R10 faulting write left page clean", 32'(r_wb), 0);
    chk(r_prf, "R10 refill write to read-only faults", 32'(r_prf), 1);

    // R11: absent page
    do_flush();
    g_prot = 2'b01;
    g_present = 1'b0;
    lookup(20'h00700, 1'b0, 1'b0);
    chk(r_pf && !r_hit, "R11 page fault reported", {r_pf, r_hit}, 2);
    g_present = 1'b1;
    lookup(20'h00700, 1'b0, 1'b0);
    chk(r_req && !r_pf, "R11 nothing installed", 32'(r_req), 1);

    // R12: idle flush and deferred flush
    do_flush();
    lookup(20'h00700, 1'b0, 1'b0);
    chk(r_req, "R12 idle flush invalidated", 32'(r_req), 1);
    lookup(20'h00800, 1'b0, 1'b1);
    chk(!r_hit && r_pfn == frame_of(20'h00800), "R12 refill completes under flush",
        32'(r_pfn), 32'(frame_of(20'h00800)));
    lookup(20'h00800, 1'b0, 1'b0);
    chk(r_req && !r_hit, "R12 deferred flush applied", 32'(r_hit), 0);

    summary_end();
  end
endmodule